// File: doc/BRIEF.md
# 64-bit Alarm Timer

A memory-mapped 64-bit up-counter for system timekeeping. A prescaler divides the input clock by a programmable amount. The counter steps once per prescaler period while it is both running and set to count up. Software sets the counter through a two-step reload: it writes a 64-bit preset and then strobes it in. It reads the counter through a snapshot that software must request. A single 64-bit compare value sets an alarm status bit when the counter steps onto it. That status drives an interrupt line, which is either a level or a one-cycle pulse. A step-length word for low-power operation is held for software but has no effect on counting.

The bus is a single-cycle write port with a combinational read. Addresses are word indices. The snapshot is controlled by a two-state machine. `SNAP_IDLE` moves to `SNAP_WAIT` on the *request* transition, which is any write to the snapshot-request address. `SNAP_WAIT` returns to `SNAP_IDLE` on the *capture* transition, which is the next prescaler tick; the snapshot registers are loaded on that same edge. No flag reports that the capture has finished. Software polls the low word until it changes.

Top module: `alarm_timer64`

## Requirements
- R1: Register map (word address): 0 control, 1 compare low, 2 compare high, 3 snapshot low, 4 snapshot high, 5 snapshot request, 6 preset low, 7 preset high, 8 preset strobe, 9 interrupt enable (bit 0), 10 alarm status (bit 0), 11 status clear, 12 step length. Control bits: 0 run, 1 count-up, 2 alarm arm, 3 pulse mode, 31:16 divider. After reset the control word, counter, preset, snapshot, status and enable read zero, and both compare words read all ones.
- R2: The counter advances by exactly one for each divider period of input clocks while both run and count-up are set, and holds its value otherwise.
- R3: A divider of zero behaves as a divider of one; the counter carries from the low word into the high word.
- R4: Any write to address 8 loads the preset into the counter at that edge and restarts the prescaler period, so the first step lands one full period later.
- R5: Any write to address 6-8's neighbour, address 5, makes the snapshot registers capture the counter value held during the next prescaler tick cycle, before that tick's step. The snapshot registers keep their old contents until then.
- R6: The status bit (address 10, bit 0) sets on the edge where an armed counter steps onto the compare value. A preset load onto that value does not set it.
- R7: A compare value already below the count never sets the status, and no status is set while the alarm is not armed.
- R8: Writing address 11 with bit 0 set clears the status.
- R9: In level mode (control bit 3 clear) the interrupt output is high exactly while status and enable are both set.
- R10: In pulse mode (control bit 3 set) the interrupt output is high for the single cycle following the edge that sets the status, and only if the enable is set.
- R11: The step-length register stores its low 10 bits, reads them back, and has no effect on counting.
- R12: Addresses 13 to 15 and the strobe addresses 5, 8 and 11 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Alarm interrupt |

## Verification
A register write is sampled on one rising edge and becomes visible at the next falling edge. The bench drives on falling edges and samples on falling edges after a settling delay. After a preset strobe, step N of the counter lands N divider periods later. The bench computes the tick cycle that follows a snapshot request from the divider and the number of wait cycles. It checks that the snapshot still holds its old value in that cycle and holds the new value one edge later. The alarm status and the interrupt are checked one cycle before the matching step and again right after it. Pulse mode is also checked one cycle later to show the pulse has dropped.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int unsigned A_CTRL     = 0;
    localparam int unsigned A_CMP_LO   = 1;
    localparam int unsigned A_CMP_HI   = 2;
    localparam int unsigned A_SNAP_LO  = 3;
    localparam int unsigned A_SNAP_HI  = 4;
    localparam int unsigned A_SNAP_REQ = 5;
    localparam int unsigned A_PRE_LO   = 6;
    localparam int unsigned A_PRE_HI   = 7;
    localparam int unsigned A_PRE_GO   = 8;
    localparam int unsigned A_IEN      = 9;
    localparam int unsigned A_ISTAT    = 10;
    localparam int unsigned A_ICLR     = 11;
    localparam int unsigned A_STEP     = 12;

    localparam int unsigned C_RUN  = 0;
    localparam int unsigned C_INC  = 1;
    localparam int unsigned C_ARM  = 2;
    localparam int unsigned C_EDGE = 3;

    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_WAIT = 1'b1
    } snap_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             resync,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] lim;

    // zero divider behaves as one; >= keeps a shrunk divider from stalling
    assign lim  = (div == '0) ? '0 : div - 1'b1;
    assign tick = (pcnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (resync || tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end

    // R4 / R2: a tick or a resync starts a fresh period
    a_r4_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick || resync) |=> (pcnt_q == '0));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             adv_en,
    input  logic             load_go,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             arm,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit
);
    logic             adv;
    logic [CNT_W-1:0] cnt_nx;

    assign adv    = tick && adv_en && !load_go;
    assign cnt_nx = cnt_q + 1'b1;
    // exact match on the stepped value only; a load never produces a hit
    assign hit    = adv && arm && (cnt_nx == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_go)
            cnt_q <= load_val;
        else if (adv)
            cnt_q <= cnt_nx;
    end

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && adv_en && !load_go) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && adv_en) && !load_go) |=> $stable(cnt_q));
    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/tmr_snapshot.sv
`timescale 1ns/1ps
module tmr_snapshot
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] snap_q
);
    snap_state_e state_q, state_d;
    logic        capture;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE: if (req)  state_d = SNAP_WAIT;
            SNAP_WAIT: if (tick) state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    assign capture = (state_q == SNAP_WAIT) && tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= cnt;
    end

    a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SNAP_WAIT) && tick) |=> (snap_q == $past(cnt)));
    a_r5_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_IDLE) |=> $stable(snap_q));
endmodule

// File: rtl/alarm_timer64.sv
`timescale 1ns/1ps
module alarm_timer64
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 16,
    parameter int STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W   = 2 * DATA_W;
    localparam int DIV_LSB = DATA_W - DIV_W;

    logic              run_q, inc_q, arm_q, edge_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  cmp_q, pre_q, cnt, snap;
    logic              ien_q, stat_q, pulse_q;
    logic [STEP_W-1:0] step_q;
    logic              tick, hit, load_go, snap_req, clr;
    logic [DATA_W-1:0] ctrl_rd;

    function automatic logic wr_at(input int unsigned a);
        return bus_wr && (bus_addr == ADDR_W'(a));
    endfunction

    assign load_go  = wr_at(A_PRE_GO);
    assign snap_req = wr_at(A_SNAP_REQ);
    assign clr      = wr_at(A_ICLR) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            inc_q  <= 1'b0;
            arm_q  <= 1'b0;
            edge_q <= 1'b0;
            div_q  <= '0;
            cmp_q  <= '1;
            pre_q  <= '0;
            ien_q  <= 1'b0;
            step_q <= '0;
        end else begin
            if (wr_at(A_CTRL)) begin
                run_q  <= bus_wdata[C_RUN];
                inc_q  <= bus_wdata[C_INC];
                arm_q  <= bus_wdata[C_ARM];
                edge_q <= bus_wdata[C_EDGE];
                div_q  <= bus_wdata[DIV_LSB +: DIV_W];
            end
            if (wr_at(A_CMP_LO)) cmp_q[DATA_W-1:0]     <= bus_wdata;
            if (wr_at(A_CMP_HI)) cmp_q[CNT_W-1:DATA_W] <= bus_wdata;
            if (wr_at(A_PRE_LO)) pre_q[DATA_W-1:0]     <= bus_wdata;
            if (wr_at(A_PRE_HI)) pre_q[CNT_W-1:DATA_W] <= bus_wdata;
            if (wr_at(A_IEN))    ien_q  <= bus_wdata[0];
            if (wr_at(A_STEP))   step_q <= bus_wdata[STEP_W-1:0];
        end
    end

    // status and pulse: a hit on the same edge as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (hit)      stat_q <= 1'b1;
            else if (clr) stat_q <= 1'b0;
            pulse_q <= hit && ien_q;
        end
    end

    assign irq = edge_q ? pulse_q : (stat_q && ien_q);

    tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div    (div_q),
        .resync (load_go),
        .tick   (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .adv_en   (run_q && inc_q),
        .load_go  (load_go),
        .load_val (pre_q),
        .cmp_val  (cmp_q),
        .arm      (arm_q),
        .cnt_q    (cnt),
        .hit      (hit)
    );

    tmr_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (snap_req),
        .tick   (tick),
        .cnt    (cnt),
        .snap_q (snap)
    );

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[C_RUN]  = run_q;
        ctrl_rd[C_INC]  = inc_q;
        ctrl_rd[C_ARM]  = arm_q;
        ctrl_rd[C_EDGE] = edge_q;
        ctrl_rd[DIV_LSB +: DIV_W] = div_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_CTRL):    bus_rdata = ctrl_rd;
            ADDR_W'(A_CMP_LO):  bus_rdata = cmp_q[DATA_W-1:0];
            ADDR_W'(A_CMP_HI):  bus_rdata = cmp_q[CNT_W-1:DATA_W];
            ADDR_W'(A_SNAP_LO): bus_rdata = snap[DATA_W-1:0];
            ADDR_W'(A_SNAP_HI): bus_rdata = snap[CNT_W-1:DATA_W];
            ADDR_W'(A_PRE_LO):  bus_rdata = pre_q[DATA_W-1:0];
            ADDR_W'(A_PRE_HI):  bus_rdata = pre_q[CNT_W-1:DATA_W];
            ADDR_W'(A_IEN):     bus_rdata = DATA_W'(ien_q);
            ADDR_W'(A_ISTAT):   bus_rdata = DATA_W'(stat_q);
            ADDR_W'(A_STEP):    bus_rdata = DATA_W'(step_q);
            default:            bus_rdata = '0;
        endcase
    end

    a_r6_fire_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> (cnt == $past(cmp_q)));
    a_r7_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_q |=> !$rose(stat_q));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q && irq) |=> (!edge_q || !irq));
endmodule

// File: tb/tb_alarm_timer64.sv
`timescale 1ns/1ps
module tb_alarm_timer64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    alarm_timer64 dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    localparam logic [31:0] RUN = 32'h1, INC = 32'h2, ARM = 32'h4, EDG = 32'h8;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd_snap(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(4'd3, lo); rd(4'd4, hi);
        v = {hi, lo};
    endtask

    function automatic logic [31:0] ctl(input int d, input logic [31:0] bits);
        return (32'(d) << 16) | bits;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v);  chk("R1 ctrl", v, 0);
        rd(4'd1, v);  chk("R1 cmp lo", v, 32'hFFFF_FFFF);
        rd(4'd2, v);  chk("R1 cmp hi", v, 32'hFFFF_FFFF);
        rd(4'd3, v);  chk("R1 snap lo", v, 0);
        rd(4'd6, v);  chk("R1 preset lo", v, 0);
        rd(4'd10, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_reads_zero();
        logic [31:0] v;
        wr(4'd5, 32'h1);
        foreach (v[i]) begin end
        for (int a = 13; a < 16; a++) begin
            rd(4'(a), v); chk("R12 unmapped", v, 0);
        end
        rd(4'd5, v);  chk("R12 strobe 5", v, 0);
        rd(4'd8, v);  chk("R12 strobe 8", v, 0);
        rd(4'd11, v); chk("R12 strobe 11", v, 0);
    endtask

    task automatic t_step();
        logic [31:0] v;
        wr(4'd12, 32'hFFFF_F2A5);
        rd(4'd12, v); chk("R11 step readback", v, 32'h2A5);
    endtask

    // load L, run with divider d, wait w cycles, request a snapshot
    task automatic t_snap(input string req, input logic [63:0] L, input int d,
                          input bit inc, input int w);
        logic [63:0] old, got, exp;
        int de, s, c;
        de = (d == 0) ? 1 : d;
        wr(4'd0, ctl(d, RUN | (inc ? INC : 32'h0)));
        wr(4'd6, L[31:0]);
        wr(4'd7, L[63:32]);
        wr(4'd8, 32'h1);                    // edge E0
        repeat (w) @(negedge clk);
        rd_snap(old);
        bus_wr = 1'b1; bus_addr = 4'd5;     // sampled at E(w+1)
        @(negedge clk);
        bus_wr = 1'b0;
        s = w + 1;
        c = s;
        while ((c % de) != de - 1) c++;
        exp = inc ? L + 64'(c / de) : L;
        repeat (c - s) @(negedge clk);
        rd_snap(got); chk({req, " R5 lag"}, got, old);
        @(negedge clk);
        rd_snap(got); chk(req, got, exp);
    endtask

    task automatic t_alarm_level();
        logic [31:0] v;
        wr(4'd0, 32'h0);
        wr(4'd1, 32'd1005); wr(4'd2, 32'h0);
        wr(4'd9, 32'h1);
        wr(4'd11, 32'h1);
        wr(4'd6, 32'd1000); wr(4'd7, 32'h0);
        wr(4'd0, ctl(1, RUN | INC | ARM));
        wr(4'd8, 32'h1);                    // E0, count 1000
        repeat (4) @(negedge clk);
        rd(4'd10, v); chk("R6 before match", v, 0);
        chk("R9 irq before match", irq, 0);
        @(negedge clk);
        rd(4'd10, v); chk("R6 on match", v, 1);
        chk("R9 irq on match", irq, 1);
        wr(4'd9, 32'h0);
        chk("R9 irq masked", irq, 0);
        rd(4'd10, v); chk("R9 status kept", v, 1);
        wr(4'd9, 32'h1);
        chk("R9 irq unmasked", irq, 1);
        wr(4'd11, 32'h1);
        rd(4'd10, v); chk("R8 clear", v, 0);
        chk("R8 irq after clear", irq, 0);
    endtask

    task automatic t_past_alarm();
        logic [31:0] v;
        wr(4'd1, 32'd500);
        repeat (50) @(negedge clk);
        rd(4'd10, v); chk("R7 past alarm", v, 0);
    endtask

    task automatic t_disarmed();
        logic [31:0] v;
        wr(4'd0, ctl(1, RUN | INC));
        wr(4'd1, 32'd2003);
        wr(4'd6, 32'd2000);
        wr(4'd8, 32'h1);
        repeat (10) @(negedge clk);
        rd(4'd10, v); chk("R7 disarmed", v, 0);
    endtask

    task automatic t_load_no_fire();
        logic [31:0] v;
        wr(4'd0, ctl(1, RUN | ARM));
        wr(4'd1, 32'd2500);
        wr(4'd6, 32'd2500);
        wr(4'd8, 32'h1);
        repeat (5) @(negedge clk);
        rd(4'd10, v); chk("R6 load onto alarm", v, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(4'd0, 32'h0);
        wr(4'd1, 32'd3005);
        wr(4'd11, 32'h1);
        wr(4'd6, 32'd3000);
        wr(4'd0, ctl(1, RUN | INC | ARM | EDG));
        wr(4'd8, 32'h1);
        repeat (4) @(negedge clk);
        chk("R10 before match", irq, 0);
        @(negedge clk);
        chk("R10 pulse", irq, 1);
        rd(4'd10, v); chk("R10 status", v, 1);
        @(negedge clk);
        chk("R10 pulse ends", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads_zero();
        t_step();
        t_snap("R2 div4 run", 64'd100, 4, 1'b1, 40);
        t_snap("R3 div0 carry", 64'h1_FFFF_FFFE, 0, 1'b1, 1);
        t_snap("R4 div3 restart", 64'd500, 3, 1'b1, 7);
        t_snap("R2 hold no count-up", 64'd777, 2, 1'b0, 20);
        t_alarm_level();
        t_past_alarm();
        t_disarmed();
        t_load_no_fire();
        t_edge();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule